// File: doc/BRIEF.md
# Flash Embedded-Operation Status Readback

This block produces the byte a host sees when it reads a two-bank flash device while an internal program or erase is under way. It tracks the state of each bank separately: idle, programming, erasing, erase-suspended, or programming while an erase is suspended. It also records which sector the erase targets. On every host read it decides between two answers. One is the array data supplied on a stand-in input port. The other is a status byte built from a polling bit, a main toggle bit and a secondary toggle bit. A separate ready line reports whether any bank is actively busy.

A command is accepted only after enough write strobes have been seen since the previous start attempt. A program needs four strobes and an erase needs six, both set by parameters. A start request that arrives earlier is discarded. The host address carries only the upper bits that choose the bank and the sector. Completion, suspend and resume events name their bank through a separate event address.

Top module: `flash_status_readback`

## Requirements
- R1: Right after reset, `dout` is 0 and `ready` is 1.
- R2: A read (`rd_en` high) to a bank with nothing to report puts that cycle's `array_data` on `dout` after the next clock edge.
- R3: A start request takes effect only if the write strobes counted since the previous start request reach 4 for a program or 6 for an erase. A strobe in the same cycle as the request counts. An early request is ignored: `ready` stays 1 and reads return array data. Every start request clears the count.
- R4: While a bank programs, a read of that bank returns a status byte. Bit 7 is the inverse of `prog_poll`. Bit 6 starts at 0 and inverts after each such read. Bit 2 stays at its value. All other bits are 0. `ready` is 0.
- R5: While a bank erases, a read of that bank returns bit 7 = 0, with bit 6 and bit 2 both starting at 0 and both inverting after each read. `ready` is 0.
- R6: A read of the bank that has no running operation returns array data, even while the other bank is busy.
- R7: After a suspend, `ready` is 1. A read of the suspended sector returns bits 7 and 6 as 1, and bit 2 inverts after each such read. A read of any other sector returns array data.
- R8: While an erase is suspended, a program start in a different sector of that bank is taken and reports as in R4 with `ready` 0. Its completion goes back to the suspended state. A program start in the suspended sector is ignored.
- R9: A resume brings back erase status as in R5 and drives `ready` to 0.
- R10: A completion returns the bank to array reads with `ready` 1. Every accepted start clears both toggle bits, so the first status read shows 0 on bits 6 and 2.
- R11: `dout` holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Host read strobe, one cycle per read |
| rd_addr | input | BANK_W+SECT_W | Read address: bank bits on top, sector bits below |
| array_data | input | DATA_W | Stand-in array contents for the current read |
| wr_strobe | input | 1 | One host write strobe of a command sequence |
| op_start | input | 1 | Request to start the operation named by `op_erase` |
| op_erase | input | 1 | 1 = erase, 0 = program |
| ev_addr | input | BANK_W+SECT_W | Bank and sector for start, done, suspend and resume |
| prog_poll | input | 1 | Bit 7 of the byte being programmed |
| op_done | input | 1 | Internal operation in the addressed bank has finished |
| suspend | input | 1 | Suspend the erase in the addressed bank |
| resume | input | 1 | Resume the suspended erase in the addressed bank |
| dout | output | DATA_W | Registered read result |
| ready | output | 1 | 1 = no bank is actively programming or erasing |

## Verification
A read sampled at a clock edge produces its result in `dout` on that same edge, one register away. The toggle bits change on that edge as well, so the value a read returns is the toggle state from before the read. `ready` is registered from the next bank state, so a start, done, suspend or resume event shows on `ready` at the edge that samples it. The bench drives inputs on the falling edge. It pushes the expected byte of each read into a queue, and a monitor pops and compares that byte on the falling edge after the sampling edge. `ready` is checked on that same falling edge after each event.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [2:0] {
    BK_IDLE      = 3'd0,
    BK_PROG      = 3'd1,
    BK_ERASE     = 3'd2,
    BK_SUSP      = 3'd3,
    BK_SUSP_PROG = 3'd4
  } bank_st_t;
endpackage

// File: rtl/fsr_cmd_count.sv
module fsr_cmd_count #(
  parameter int PROG_STROBES  = 4,
  parameter int ERASE_STROBES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_strobe,
  input  logic op_start,
  output logic prog_ok,
  output logic erase_ok
);
  localparam int CNT_W = $clog2(ERASE_STROBES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = ERASE_STROBES[CNT_W-1:0];
  localparam logic [CNT_W:0] NEED_P = PROG_STROBES[CNT_W:0];
  localparam logic [CNT_W:0] NEED_E = ERASE_STROBES[CNT_W:0];

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   seen;

  // strobe in the request cycle counts toward the threshold
  assign seen     = {1'b0, cnt} + {{CNT_W{1'b0}}, wr_strobe};
  assign prog_ok  = seen >= NEED_P;
  assign erase_ok = seen >= NEED_E;

  always_ff @(posedge clk) begin
    if (rst)                             cnt <= '0;
    else if (op_start)                   cnt <= '0;
    else if (wr_strobe && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // R3: count never passes the erase threshold
  assert_cnt_sat_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX);
  // R3: a start request always restarts the sequence
  assert_cnt_clear_R3: assert property (@(posedge clk) disable iff (rst)
    op_start |=> (cnt == '0));
endmodule

// File: rtl/fsr_bank.sv
module fsr_bank
  import fsr_pkg::*;
#(
  parameter int SECT_W   = 4,
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TGL_BIT  = 6,
  parameter int TGL2_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_hit,
  input  logic [SECT_W-1:0] ev_sect,
  input  logic              go_prog,
  input  logic              go_erase,
  input  logic              op_done,
  input  logic              suspend,
  input  logic              resume,
  input  logic              prog_poll,
  input  logic              rd_hit,
  input  logic [SECT_W-1:0] rd_sect,
  output logic              stat_en,
  output logic [DATA_W-1:0] stat_word,
  output logic              busy_nx
);
  bank_st_t          st, st_d;
  logic              tgl_a, tgl_b, poll_q;
  logic [SECT_W-1:0] ers_sect;
  logic              prog_acc, erase_acc, start_acc;
  logic              show_prog, show_erase, show_susp;

  assign prog_acc  = ev_hit && go_prog &&
                     (st == BK_IDLE || (st == BK_SUSP && ev_sect != ers_sect));
  assign erase_acc = ev_hit && go_erase && st == BK_IDLE;
  assign start_acc = prog_acc || erase_acc;

  always_comb begin
    st_d = st;
    unique case (st)
      BK_IDLE:      if (prog_acc) st_d = BK_PROG;
                    else if (erase_acc) st_d = BK_ERASE;
      BK_PROG:      if (ev_hit && op_done) st_d = BK_IDLE;
      BK_ERASE:     if (ev_hit && op_done) st_d = BK_IDLE;
                    else if (ev_hit && suspend) st_d = BK_SUSP;
      BK_SUSP:      if (prog_acc) st_d = BK_SUSP_PROG;
                    else if (ev_hit && resume) st_d = BK_ERASE;
      BK_SUSP_PROG: if (ev_hit && op_done) st_d = BK_SUSP;
      default:      st_d = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= BK_IDLE;
      poll_q   <= 1'b0;
      ers_sect <= '0;
    end else begin
      st <= st_d;
      if (prog_acc)  poll_q   <= ~prog_poll;
      if (erase_acc) ers_sect <= ev_sect;
    end
  end

  assign busy_nx = (st_d == BK_PROG) || (st_d == BK_ERASE) || (st_d == BK_SUSP_PROG);

  assign show_prog  = rd_hit && (st == BK_PROG || st == BK_SUSP_PROG);
  assign show_erase = rd_hit && st == BK_ERASE;
  assign show_susp  = rd_hit && st == BK_SUSP && rd_sect == ers_sect;
  assign stat_en    = show_prog || show_erase || show_susp;

  always_comb begin
    stat_word = '0;
    if (show_prog) begin
      stat_word[POLL_BIT] = poll_q;
      stat_word[TGL_BIT]  = tgl_a;
      stat_word[TGL2_BIT] = tgl_b;
    end else if (show_erase) begin
      stat_word[TGL_BIT]  = tgl_a;
      stat_word[TGL2_BIT] = tgl_b;
    end else if (show_susp) begin
      stat_word[POLL_BIT] = 1'b1;
      stat_word[TGL_BIT]  = 1'b1;
      stat_word[TGL2_BIT] = tgl_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start_acc) begin
      tgl_a <= 1'b0;
      tgl_b <= 1'b0;
    end else begin
      if (show_prog || show_erase) tgl_a <= ~tgl_a;
      if (show_erase || show_susp) tgl_b <= ~tgl_b;
    end
  end

  // R10: a new operation starts with both toggles at 0
  assert_tgl_clear_R10: assert property (@(posedge clk) disable iff (rst)
    start_acc |=> (!tgl_a && !tgl_b));
  // R4: main toggle flips on every program status read
  assert_tgl_run_R4: assert property (@(posedge clk) disable iff (rst)
    show_prog |=> (tgl_a != $past(tgl_a)));
  // R4: secondary toggle steady through a program
  assert_tgl2_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (st == BK_PROG) |=> $stable(tgl_b));
  // R7: suspended state is entered only from an erase or a nested program
  assert_susp_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (st == BK_SUSP && $past(st) != BK_SUSP) |->
      ($past(st) == BK_ERASE || $past(st) == BK_SUSP_PROG));
endmodule

// File: rtl/flash_status_readback.sv
module flash_status_readback #(
  parameter int BANK_W        = 1,
  parameter int SECT_W        = 4,
  parameter int DATA_W        = 8,
  parameter int POLL_BIT      = 7,
  parameter int TGL_BIT       = 6,
  parameter int TGL2_BIT      = 2,
  parameter int PROG_STROBES  = 4,
  parameter int ERASE_STROBES = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [BANK_W+SECT_W-1:0] rd_addr,
  input  logic [DATA_W-1:0]        array_data,
  input  logic                     wr_strobe,
  input  logic                     op_start,
  input  logic                     op_erase,
  input  logic [BANK_W+SECT_W-1:0] ev_addr,
  input  logic                     prog_poll,
  input  logic                     op_done,
  input  logic                     suspend,
  input  logic                     resume,
  output logic [DATA_W-1:0]        dout,
  output logic                     ready
);
  localparam int ADDR_W = BANK_W + SECT_W;
  localparam int NBANK  = 1 << BANK_W;

  logic              prog_ok, erase_ok;
  logic [BANK_W-1:0] rd_bank, ev_bank;
  logic [SECT_W-1:0] rd_sect, ev_sect;
  logic [NBANK-1:0]  stat_en, busy_nx;
  logic [DATA_W-1:0] stat_words [NBANK];
  logic              any_stat;
  logic [DATA_W-1:0] any_word;

  assign rd_bank = rd_addr[ADDR_W-1 -: BANK_W];
  assign ev_bank = ev_addr[ADDR_W-1 -: BANK_W];
  assign rd_sect = rd_addr[SECT_W-1:0];
  assign ev_sect = ev_addr[SECT_W-1:0];

  fsr_cmd_count #(
    .PROG_STROBES (PROG_STROBES),
    .ERASE_STROBES(ERASE_STROBES)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .wr_strobe(wr_strobe),
    .op_start (op_start),
    .prog_ok  (prog_ok),
    .erase_ok (erase_ok)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    fsr_bank #(
      .SECT_W  (SECT_W),
      .DATA_W  (DATA_W),
      .POLL_BIT(POLL_BIT),
      .TGL_BIT (TGL_BIT),
      .TGL2_BIT(TGL2_BIT)
    ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .ev_hit   (ev_bank == BANK_W'(b)),
      .ev_sect  (ev_sect),
      .go_prog  (op_start && !op_erase && prog_ok),
      .go_erase (op_start && op_erase && erase_ok),
      .op_done  (op_done),
      .suspend  (suspend),
      .resume   (resume),
      .prog_poll(prog_poll),
      .rd_hit   (rd_en && rd_bank == BANK_W'(b)),
      .rd_sect  (rd_sect),
      .stat_en  (stat_en[b]),
      .stat_word(stat_words[b]),
      .busy_nx  (busy_nx[b])
    );
  end

  always_comb begin
    any_stat = 1'b0;
    any_word = '0;
    for (int i = 0; i < NBANK; i++) begin
      any_stat = any_stat | stat_en[i];
      any_word = any_word | stat_words[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      ready <= 1'b1;
    end else begin
      ready <= ~|busy_nx;
      if (rd_en) dout <= any_stat ? any_word : array_data;
    end
  end

  // R11: output holds when no read is sampled
  assert_dout_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(dout));
  // R2: a read with no status to report returns the array byte
  assert_array_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !any_stat) |=> (dout == $past(array_data)));
endmodule

// File: tb/flash_status_readback_test.sv
module flash_status_readback_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_en = 1'b0;
  logic [4:0] rd_addr = '0;
  logic [7:0] array_data = '0;
  logic       wr_strobe = 1'b0;
  logic       op_start = 1'b0;
  logic       op_erase = 1'b0;
  logic [4:0] ev_addr = '0;
  logic       prog_poll = 1'b0;
  logic       op_done = 1'b0;
  logic       suspend = 1'b0;
  logic       resume = 1'b0;
  logic [7:0] dout;
  logic       ready;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic seen = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  flash_status_readback uut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .array_data(array_data), .wr_strobe(wr_strobe), .op_start(op_start),
    .op_erase(op_erase), .ev_addr(ev_addr), .prog_poll(prog_poll),
    .op_done(op_done), .suspend(suspend), .resume(resume),
    .dout(dout), .ready(ready)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected byte of each sampled read
  always @(posedge clk) seen <= rd_en;
  always @(negedge clk) begin
    if (seen && exp_q.size() > 0) check(dout, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic rd(input logic [4:0] a, input logic [7:0] arr,
                    input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; rd_addr = a; array_data = arr;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      wr_strobe = 1'b1; @(negedge clk); wr_strobe = 1'b0; @(negedge clk);
    end
  endtask

  task automatic start(input logic ers, input logic [4:0] a,
                       input logic with_strobe, input logic pbit);
    op_start = 1'b1; op_erase = ers; ev_addr = a;
    wr_strobe = with_strobe; prog_poll = pbit;
    @(negedge clk);
    op_start = 1'b0; wr_strobe = 1'b0;
  endtask

  task automatic done(input logic [4:0] a);
    op_done = 1'b1; ev_addr = a; @(negedge clk); op_done = 1'b0;
  endtask

  task automatic susp(input logic [4:0] a);
    suspend = 1'b1; ev_addr = a; @(negedge clk); suspend = 1'b0;
  endtask

  task automatic resm(input logic [4:0] a);
    resume = 1'b1; ev_addr = a; @(negedge clk); resume = 1'b0;
  endtask

  task automatic chk_ready(input logic exp, input string tag);
    check({7'b0, ready}, {7'b0, exp}, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(dout, 8'h00, "R1 dout after reset");
    chk_ready(1'b1, "R1 ready after reset");

    rd(5'h03, 8'h5A, 8'h5A, "R2 idle read");

    // R3: program with three strobes is dropped
    strobes(3);
    start(1'b0, 5'h02, 1'b0, 1'b1);
    chk_ready(1'b1, "R3 early program ignored");
    rd(5'h02, 8'h11, 8'h11, "R3 array after early program");

    // R3 and R4: fourth strobe with the request
    strobes(3);
    start(1'b0, 5'h02, 1'b1, 1'b1);
    chk_ready(1'b0, "R4 busy during program");
    rd(5'h02, 8'hFF, 8'h00, "R4 status read 1");
    rd(5'h05, 8'hFF, 8'h40, "R4 status read 2");
    rd(5'h02, 8'hFF, 8'h00, "R4 status read 3");
    rd(5'h12, 8'h77, 8'h77, "R6 other bank array");
    done(5'h02);
    chk_ready(1'b1, "R10 ready after done");
    rd(5'h02, 8'h3C, 8'h3C, "R10 array after done");

    // R3: erase with five strobes is dropped
    strobes(5);
    start(1'b1, 5'h02, 1'b0, 1'b0);
    chk_ready(1'b1, "R3 early erase ignored");
    strobes(5);
    start(1'b1, 5'h02, 1'b1, 1'b0);
    chk_ready(1'b0, "R5 busy during erase");
    rd(5'h02, 8'hFF, 8'h00, "R5 erase read 1");
    rd(5'h07, 8'hFF, 8'h44, "R5 erase read 2");
    rd(5'h02, 8'hFF, 8'h00, "R5 erase read 3");
    rd(5'h19, 8'h21, 8'h21, "R6 other bank during erase");

    // R7: suspend; toggles now tgl_a=1 tgl_b=1
    susp(5'h02);
    chk_ready(1'b1, "R7 ready in suspend");
    rd(5'h02, 8'hEE, 8'hC4, "R7 suspended sector read 1");
    rd(5'h02, 8'hEE, 8'hC0, "R7 suspended sector read 2");
    rd(5'h04, 8'h99, 8'h99, "R7 other sector array");

    // R8: program into suspended sector is dropped
    strobes(3);
    start(1'b0, 5'h02, 1'b1, 1'b1);
    chk_ready(1'b1, "R8 program in suspended sector ignored");
    strobes(3);
    start(1'b0, 5'h04, 1'b1, 1'b0);
    chk_ready(1'b0, "R8 busy nested program");
    rd(5'h04, 8'h00, 8'h80, "R8 nested program read 1");
    rd(5'h04, 8'h00, 8'hC0, "R8 nested program read 2");
    done(5'h04);
    chk_ready(1'b1, "R8 back to suspend");
    rd(5'h02, 8'h00, 8'hC0, "R8 suspended sector after nested");

    // R9: resume; toggles tgl_a=0 tgl_b=1
    resm(5'h02);
    chk_ready(1'b0, "R9 busy after resume");
    rd(5'h02, 8'hFF, 8'h04, "R9 erase read after resume 1");
    rd(5'h02, 8'hFF, 8'h40, "R9 erase read after resume 2");
    done(5'h02);
    chk_ready(1'b1, "R10 ready after erase done");
    rd(5'h02, 8'h6B, 8'h6B, "R10 array after erase done");

    // R10: toggles restart on new op
    strobes(4);
    start(1'b0, 5'h13, 1'b0, 1'b0);
    rd(5'h13, 8'h00, 8'h80, "R10 toggle restart");
    rd(5'h02, 8'h5D, 8'h5D, "R6 idle bank while bank1 programs");
    done(5'h13);

    // R11: no reads, dout holds
    array_data = 8'hA5;
    repeat (3) @(negedge clk);
    check(dout, 8'h5D, "R11 dout holds");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule